// File: doc/BRIEF.md
# Four-Rail Power Sequencer with Reset Hold

This block brings up four downstream converter rails, one after another or together, once the upstream hot-swap stage reports that input power is good. For each rail it waits for an enable flag (meaning the rail's trip level has been reached). It then counts a per-rail delay chosen by a two-bit select. When the delay has elapsed, it raises that rail's good output, which also serves as the enable of a downstream converter.

Wiring one rail's good output into the next rail's enable flag gives a relay chain. Tying several enable flags together starts those rails in parallel.

A system reset output stays asserted until power-good and all four rail-good outputs are active. It is released only after they have remained so for a fixed hold time. If any of them falls, reset is asserted again at once. A host-driven resequence input drops every rail and restarts the sequence without cycling power. All timing is counted in enables from a time-base tick, nominally one per microsecond.

Top module: `rseq_top`

## Requirements
- R1: While rst_ni is low, every bit of rail_good_o is 0 and reset_no is 0.
- R2: Rail k's good output rises once it has counted `lim` ticks in which en_i[k], pgood_i and not mrc_i all held. Delay select dly_sel_i[2k+1:2k] sets `lim` to TICKS_PER_MS times 100 (code 00), 50 (01), 200 (10) or 400 (11). The output rises on the clock edge that samples the last such tick.
- R3: If en_i[k] is low at a clock edge, rail k's count restarts from zero and its good output is 0 after that edge.
- R4: Feeding rail_good_o[k-1] into en_i[k] makes the rails come up strictly in order, each after its own delay.
- R5: reset_no rises once pgood_i, every rail_good_o bit and not mrc_i have held together for TICKS_PER_MS*HOLD_MS ticks. It rises on the edge that samples the last such tick.
- R6: reset_no is 0 after the first clock edge at which pgood_i is low, mrc_i is high or any rail_good_o bit is low.
- R7: A clock edge with pgood_i low clears every rail_good_o bit and every rail count.
- R8: While mrc_i is high, all rail_good_o bits and reset_no are 0. After its falling edge, sequencing starts again from zero counts.
- R9: Counts advance only at edges where tick_i is 1; without ticks no output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| pgood_i | input | 1 | Input power good from the hot-swap stage |
| mrc_i | input | 1 | Host resequence request, active high |
| en_i | input | NUM_RAILS | Per-rail enable flag (trip level reached) |
| dly_sel_i | input | 2*NUM_RAILS | Two-bit delay select per rail, rail k at [2k+1:2k] |
| rail_good_o | output | NUM_RAILS | Per-rail good / downstream enable |
| reset_no | output | 1 | System reset, active low |

## Verification
The bench targets the following corner cases:

- **Enable dropped for a single cycle partway through a count.** A design that paused instead of restarting would raise the rail early.
- **Exact edge at which each delay code completes.** An off-by-one limit shows as a good output one tick early or late.
- **Relay chain with mixed codes.** A rail that looked at its own timer rather than its enable would break the order.
- **Resequence held high mid-count and released.** A design acting only on the rising edge would keep stale counts.
- **Power-good drop and single-rail drop after reset release.** A hold counter that failed to clear would release reset without the full hold.
- **Tick gaps.** A design counting clocks instead of ticks would finish during a gap.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef logic [1:0] dly_sel_t;

  localparam int unsigned MAX_DLY_MS = 400;

  function automatic int unsigned dly_ms(dly_sel_t sel);
    case (sel)
      2'b00:   return 100;
      2'b01:   return 50;
      2'b10:   return 200;
      default: return 400;
    endcase
  endfunction
endpackage

// File: rtl/rseq_timer.sv
// Tick-counting qualifier: done_o rises after lim_i qualified ticks, clears when ok_i drops.
module rseq_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ok_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!ok_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (cnt_q >= lim_i - CNT_W'(1)) done_q <= 1'b1;
      else                            cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/rseq_rail.sv
module rseq_rail
  import rseq_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int CNT_W        = 20
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     en_i,
  input  logic     tick_i,
  input  dly_sel_t sel_i,
  output logic     good_o
);
  logic [CNT_W-1:0] lim;

  assign lim = CNT_W'(dly_ms(sel_i) * TICKS_PER_MS);

  rseq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ok_i   (run_i && en_i),
    .tick_i (tick_i),
    .lim_i  (lim),
    .done_o (good_o)
  );
endmodule

// File: rtl/rseq_top.sv
module rseq_top
  import rseq_pkg::*;
#(
  parameter int NUM_RAILS    = 4,
  parameter int TICKS_PER_MS = 1000,
  parameter int HOLD_MS      = 100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   pgood_i,
  input  logic                   mrc_i,
  input  logic [NUM_RAILS-1:0]   en_i,
  input  logic [2*NUM_RAILS-1:0] dly_sel_i,
  output logic [NUM_RAILS-1:0]   rail_good_o,
  output logic                   reset_no
);
  localparam int RAIL_MAX   = int'(MAX_DLY_MS) * TICKS_PER_MS;
  localparam int RAIL_W     = $clog2(RAIL_MAX + 1);
  localparam int HOLD_TICKS = HOLD_MS * TICKS_PER_MS;
  localparam int HOLD_W     = $clog2(HOLD_TICKS + 1);

  logic run;
  logic all_ok;

  // Resequence held high clears everything; release restarts from zero.
  assign run = pgood_i && !mrc_i;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    rseq_rail #(
      .TICKS_PER_MS (TICKS_PER_MS),
      .CNT_W        (RAIL_W)
    ) i_rail (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .en_i   (en_i[g]),
      .tick_i (tick_i),
      .sel_i  (dly_sel_i[2*g +: 2]),
      .good_o (rail_good_o[g])
    );
  end

  assign all_ok = run && (&rail_good_o);

  rseq_timer #(.CNT_W(HOLD_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ok_i   (all_ok),
    .tick_i (tick_i),
    .lim_i  (HOLD_W'(HOLD_TICKS)),
    .done_o (reset_no)
  );
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk #(
  parameter int NUM_RAILS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 pgood_i,
  input logic                 mrc_i,
  input logic [NUM_RAILS-1:0] en_i,
  input logic [NUM_RAILS-1:0] rail_good_o,
  input logic                 reset_no
);
  p_pg_low_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgood_i |=> (rail_good_o == '0));

  p_mrc_holds_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrc_i |=> (rail_good_o == '0) && !reset_no);

  p_reset_forced_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pgood_i || mrc_i || (rail_good_o != '1)) |=> !reset_no);

  p_release_qualified_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_no) |-> $past(pgood_i) && ($past(rail_good_o) == '1));

  p_release_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_no) |-> $past(tick_i));

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail_chk
    p_en_low_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[g] |=> !rail_good_o[g]);

    p_rise_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rail_good_o[g]) |-> $past(tick_i) && $past(en_i[g]));
  end
endmodule

bind rseq_top rseq_chk #(.NUM_RAILS(NUM_RAILS)) i_rseq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .pgood_i     (pgood_i),
  .mrc_i       (mrc_i),
  .en_i        (en_i),
  .rail_good_o (rail_good_o),
  .reset_no    (reset_no)
);

// File: tb/test_rseq_top.sv
`timescale 1ns/1ps
module test_rseq_top;
  localparam int NR   = 4;
  localparam int TPM  = 2;
  localparam int HMS  = 100;
  localparam int WDOG = 150000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic          pgood_i = 1'b0;
  logic          mrc_i = 1'b0;
  logic [NR-1:0] en_i = '0;
  logic [2*NR-1:0] dly_sel_i = '0;
  wire  [NR-1:0] rail_good_o;
  wire           reset_no;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string tag   = "R1";
  bit    tick_on = 1'b1;
  bit    relay   = 1'b0;
  logic  en0     = 1'b0;
  int    tdiv    = 0;

  always #2.5 clk_i = ~clk_i;

  rseq_top #(.NUM_RAILS(NR), .TICKS_PER_MS(TPM), .HOLD_MS(HMS)) i_rseq_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pgood_i(pgood_i),
    .mrc_i(mrc_i), .en_i(en_i), .dly_sel_i(dly_sel_i),
    .rail_good_o(rail_good_o), .reset_no(reset_no)
  );

  function automatic int lim(logic [1:0] c);
    case (c)
      2'b00:   return 100 * TPM;
      2'b01:   return 50 * TPM;
      2'b10:   return 200 * TPM;
      default: return 400 * TPM;
    endcase
  endfunction

  // Reference model from the requirements
  int        m_cnt [NR];
  logic [NR-1:0] m_good;
  int        m_hcnt;
  logic      m_rel;

  always @(posedge clk_i or negedge rst_ni) begin : model
    logic ok;
    if (!rst_ni) begin
      for (int k = 0; k < NR; k++) m_cnt[k] = 0;
      m_good = '0; m_hcnt = 0; m_rel = 1'b0;
    end else begin
      ok = pgood_i && !mrc_i && (&m_good);
      for (int k = 0; k < NR; k++) begin
        if (!pgood_i || mrc_i || !en_i[k]) begin
          m_cnt[k] = 0; m_good[k] = 1'b0;
        end else if (tick_i && !m_good[k]) begin
          m_cnt[k]++;
          if (m_cnt[k] >= lim(dly_sel_i[2*k +: 2])) m_good[k] = 1'b1;
        end
      end
      if (!ok) begin
        m_hcnt = 0; m_rel = 1'b0;
      end else if (tick_i && !m_rel) begin
        m_hcnt++;
        if (m_hcnt >= HMS * TPM) m_rel = 1'b1;
      end
    end
  end

  always @(negedge clk_i) begin
    n_cmp++;
    if (rail_good_o !== m_good) begin
      n_bad++;
      $display("FAIL %s rail_good_o act=%b exp=%b at cycle %0d", tag, rail_good_o, m_good, cyc);
    end
    n_cmp++;
    if (reset_no !== m_rel) begin
      n_bad++;
      $display("FAIL %s reset_no act=%b exp=%b at cycle %0d",
               m_rel ? "R5" : "R6", reset_no, m_rel, cyc);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WDOG) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WDOG);
      summary();
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tdiv++;
      tick_i = tick_on && tdiv[0];
      if (relay) en_i = {rail_good_o[NR-2:0], en0};
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    tag = "R1";
    step(6);
    rst_ni = 1'b1;
    step(4);

    // Parallel start, several code sets
    tag = "R2";
    pgood_i = 1'b1;
    for (int it = 0; it < 4; it++) begin
      en_i = '0;
      dly_sel_i = (it == 0) ? 8'h00 : (it == 1) ? 8'hFF : 8'($urandom);
      step(3);
      en_i = '1;
      step(2400);
    end

    // Relay chain
    tag = "R4";
    en_i = '0; step(3);
    dly_sel_i = 8'b01_10_00_01;
    relay = 1'b1; en0 = 1'b1;
    step(3000);
    relay = 1'b0;

    // Enable glitch mid count
    tag = "R3";
    en_i = '0; dly_sel_i = 8'h00; step(3);
    en_i = '1; step(200);
    en_i[1] = 1'b0; step(1);
    en_i[1] = 1'b1; step(1200);
    en_i[2] = 1'b0; step(5);
    en_i[2] = 1'b1; step(1000);

    // Power-good loss
    tag = "R7";
    pgood_i = 1'b0; step(10);
    pgood_i = 1'b1; step(150);
    pgood_i = 1'b0; step(3);
    pgood_i = 1'b1; step(1300);

    // Resequence input
    tag = "R8";
    mrc_i = 1'b1; step(300);
    mrc_i = 1'b0; step(250);
    mrc_i = 1'b1; step(2);
    mrc_i = 1'b0; step(1300);

    // Tick gaps
    tag = "R9";
    en_i = '0; step(3);
    en_i = '1; tick_on = 1'b0; step(600);
    tick_on = 1'b1; step(1300);

    // Random mix
    tag = "R2";
    for (int it = 0; it < 30; it++) begin
      en_i      = 4'($urandom);
      pgood_i   = ($urandom % 8) != 0;
      mrc_i     = ($urandom % 10) == 0;
      relay     = ($urandom % 4) == 0;
      en0       = 1'b1;
      tick_on   = ($urandom % 6) != 0;
      if (($urandom % 3) == 0) dly_sel_i = 8'($urandom);
      step(50 + int'($urandom % 1500));
    end
    relay = 1'b0;
    tick_on = 1'b1;
    step(10);
    summary();
  end
endmodule